// File: doc/BRIEF.md
# Multi-Queue Transaction Retry and Timeout Manager

This block follows one outstanding request transaction on each of several transmit queues of a serial-bus link controller. Each queue has its own transaction timer. Once a queue's request has been handed over, the timer needs no further host action until the transaction ends. The timer presents the request to a simple transmit handshake. It resends the request after every busy acknowledge, up to a retry limit. After a pending acknowledge it waits for a split response while a countdown runs on a tick strobe.

Every transaction that ends on its own produces exactly one status-tagged record on a response-push port. The record is the real response when one matched. When the retries ran out or the split wait timed out, the record is a synthesized dummy. A transaction that is cancelled by a host abort or by a bus reset produces no record.

The host reads per-queue done, error and retry-active flags. It picks one timer by number through a control register, and the detail of that timer then appears in three status registers.

Top module: `xact_retry_mgr`

## Requirements
- R1: After reset every done flag is 1, every error flag is 0, the retry-active flags are 0, `tx_req` is 0 and no record is pushed.
- R2: A start strobe for an idle queue captures destination ID, 48-bit offset, tCode, speed and tLabel. It clears that queue's done flag and sets its retry-active flag. A start for a queue that is not idle is ignored, and the captured fields keep their values.
- R3: Each busy acknowledge adds one to the queue's retry count, and the request is presented again. The acknowledge that brings the count to RETRY_LIMIT ends the transaction with a dummy record of status 2 (busy exhausted).
- R4: A pending acknowledge loads the split timer with SPLIT_TIMEOUT and clears the retry-active flag while done stays 0 (split wait). Each tick lowers the timer by one. When it reaches 0 without a match, the transaction ends with a dummy record of status 3 (timeout).
- R5: During split wait, a response whose source ID equals the stored destination ID and whose tLabel equals the stored tLabel ends the transaction. It produces a real record (`rec_dummy` 0) carrying the response code, with status 0 when the code is 0 and status 1 otherwise.
- R6: A response that does not match on both source ID and tLabel has no effect on any timer.
- R7: The done flag is set and the error flag is set to (status != 0) on the same clock edge that raises `rec_valid`. At most one record is pushed per cycle. When several queues finish together, the lowest-numbered queue is pushed first.
- R8: A host abort returns the named queue to idle and sets its done flag. It pushes no record and leaves the error flag unchanged.
- R9: A bus reset returns every queue to idle and pushes no record.
- R10: `tx_req` is high while any queue is in its send phase, and `tx_q` names the lowest-numbered such queue. `tx_ack` applies to that queue only.
- R11: Register window (read data registered one cycle after the address). Offset 0x60 holds the timer select in bits [2:0] (writable), the done flags in bits [8+i], the error flags in [16+i] and the retry-active flags in [24+i]. With select `s` < number of queues: 0x64 = {dest ID, offset[47:32]}; 0x68 = offset[31:0]; 0x6C = {tCode[31:28], speed[27:26], tLabel[25:20], retry count[19:16], split timer[15:0]}. A select of the number of queues or above reads 0 in the three status registers. Timer number 4 belongs to the control-type queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start a transaction on `start_q` |
| start_q | input | QW | Queue number for the start |
| start_dest | input | IDW | Destination node ID |
| start_offset | input | 48 | Destination offset |
| start_tcode | input | 4 | Transaction code |
| start_spd | input | 2 | Speed code |
| start_tlabel | input | TLW | Transaction label |
| tx_req | output | 1 | A request is waiting for the bus |
| tx_q | output | QW | Queue whose request is presented |
| tx_ack | input | 1 | Acknowledge strobe for the presented request |
| tx_busy | input | 1 | With `tx_ack`: 1 busy, 0 pending |
| tick | input | 1 | Split-timer time base strobe |
| rsp_valid | input | 1 | Response arrival strobe |
| rsp_src | input | IDW | Response source ID |
| rsp_tlabel | input | TLW | Response tLabel |
| rsp_rcode | input | 4 | Response code |
| abort_valid | input | 1 | Host abort of `abort_q` |
| abort_q | input | QW | Queue to abort |
| bus_reset | input | 1 | Bus reset: drop every transaction |
| rec_valid | output | 1 | Push strobe for the response record |
| rec_q | output | QW | Queue of the record |
| rec_status | output | 2 | 0 ok, 1 response error, 2 busy exhausted, 3 timeout |
| rec_dummy | output | 1 | Record is synthesized |
| rec_rcode | output | 4 | Response code (0 for dummies) |
| rec_tlabel | output | TLW | tLabel of the finished transaction |
| done | output | NQ | Per-queue done flags |
| err | output | NQ | Per-queue error flags |
| retry_act | output | NQ | Per-queue retry-active flags |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with six queues, RETRY_LIMIT = 3 and SPLIT_TIMEOUT = 4. With these values, busy exhaustion takes three acknowledges and a split timeout takes four ticks, so each ending path, including both dummy statuses, completes within a few cycles. Six queues put the control-type timer at number 4 and leave select values 6 and 7 free to check the zeroed window. They also let two queues time out on the same edge, which exercises the push ordering.

// File: rtl/xtm_pkg.sv
package xtm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_FIN} tstate_e;
  typedef enum logic [1:0] {RS_OK = 2'd0, RS_RSPERR = 2'd1, RS_BUSY = 2'd2, RS_TIMEOUT = 2'd3} rstat_e;
  localparam logic [7:0] ADDR_CTRL = 8'h60;
  localparam logic [7:0] ADDR_ST1  = 8'h64;
  localparam logic [7:0] ADDR_ST2  = 8'h68;
  localparam logic [7:0] ADDR_ST3  = 8'h6C;
endpackage

// File: rtl/xtm_first.sv
module xtm_first #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        gnt    = '0;
        gnt[k] = 1'b1;
        idx    = IW'(k);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xtm_timer.sv
module xtm_timer
  import xtm_pkg::*;
#(
  parameter int IDW = 16,
  parameter int TLW = 6,
  parameter int RW = 4,
  parameter int SW = 16,
  parameter int RETRY_LIMIT = 8,
  parameter int SPLIT_TIMEOUT = 200
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [IDW-1:0] start_dest,
  input  logic [47:0]    start_offset,
  input  logic [3:0]     start_tcode,
  input  logic [1:0]     start_spd,
  input  logic [TLW-1:0] start_tlabel,
  input  logic           ack,
  input  logic           ack_busy,
  input  logic           tick,
  input  logic           rsp_valid,
  input  logic [IDW-1:0] rsp_src,
  input  logic [TLW-1:0] rsp_tlabel,
  input  logic [3:0]     rsp_rcode,
  input  logic           kill,
  input  logic           grant,
  output logic           sending,
  output logic           finishing,
  output logic           done,
  output logic           err,
  output logic [1:0]     fin_status,
  output logic           fin_dummy,
  output logic [3:0]     fin_rcode,
  output logic [IDW-1:0] dest,
  output logic [47:0]    offset,
  output logic [3:0]     tcode,
  output logic [1:0]     spd,
  output logic [TLW-1:0] tlabel,
  output logic [RW-1:0]  retry,
  output logic [SW-1:0]  split
);
  localparam logic [RW-1:0] LIM = RW'(RETRY_LIMIT);
  localparam logic [SW-1:0] TMO = SW'(SPLIT_TIMEOUT);

  tstate_e state;
  rstat_e  fstat;
  logic    hit;

  assign hit        = rsp_valid && (rsp_src == dest) && (rsp_tlabel == tlabel);
  assign sending    = (state == ST_SEND);
  assign finishing  = (state == ST_FIN);
  assign done       = (state == ST_IDLE);
  assign fin_status = fstat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  fstat <= RS_OK;  fin_dummy <= 1'b0;  fin_rcode <= '0;
      err <= 1'b0;  retry <= '0;  split <= '0;
      dest <= '0;  offset <= '0;  tcode <= '0;  spd <= '0;  tlabel <= '0;
    end else if (kill) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          dest <= start_dest;  offset <= start_offset;  tcode <= start_tcode;
          spd <= start_spd;  tlabel <= start_tlabel;
          retry <= '0;  split <= '0;  state <= ST_SEND;
        end
        ST_SEND: if (ack) begin
          if (ack_busy) begin
            retry <= retry + RW'(1);
            if (retry + RW'(1) == LIM) begin
              fstat <= RS_BUSY;  fin_dummy <= 1'b1;  fin_rcode <= '0;  state <= ST_FIN;
            end
          end else begin
            split <= TMO;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (hit) begin
          fstat     <= (rsp_rcode == 4'd0) ? RS_OK : RS_RSPERR;
          fin_dummy <= 1'b0;
          fin_rcode <= rsp_rcode;
          state     <= ST_FIN;
        end else if (tick) begin
          split <= split - SW'(1);
          if (split == SW'(1)) begin
            fstat <= RS_TIMEOUT;  fin_dummy <= 1'b1;  fin_rcode <= '0;  state <= ST_FIN;
          end
        end
        ST_FIN: if (grant) begin
          err   <= (fstat != RS_OK);
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the retry count never passes the limit
  p_retry_bound_r3: assert property (@(posedge clk) disable iff (rst) retry <= LIM);
  // R4: every tick in split wait without a match lowers the split timer by one
  p_split_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && tick && !hit && !kill) |=> (split == $past(split) - SW'(1)));
  // R6: without a match, tick or kill, split wait persists
  p_wait_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !hit && !tick && !kill) |=> (state == ST_WAIT));
endmodule

// File: rtl/xact_retry_mgr.sv
module xact_retry_mgr
  import xtm_pkg::*;
#(
  parameter int NQ = 6,
  parameter int IDW = 16,
  parameter int TLW = 6,
  parameter int RW = 4,
  parameter int SW = 16,
  parameter int RETRY_LIMIT = 8,
  parameter int SPLIT_TIMEOUT = 200,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_valid,
  input  logic [QW-1:0]  start_q,
  input  logic [IDW-1:0] start_dest,
  input  logic [47:0]    start_offset,
  input  logic [3:0]     start_tcode,
  input  logic [1:0]     start_spd,
  input  logic [TLW-1:0] start_tlabel,
  output logic           tx_req,
  output logic [QW-1:0]  tx_q,
  input  logic           tx_ack,
  input  logic           tx_busy,
  input  logic           tick,
  input  logic           rsp_valid,
  input  logic [IDW-1:0] rsp_src,
  input  logic [TLW-1:0] rsp_tlabel,
  input  logic [3:0]     rsp_rcode,
  input  logic           abort_valid,
  input  logic [QW-1:0]  abort_q,
  input  logic           bus_reset,
  output logic           rec_valid,
  output logic [QW-1:0]  rec_q,
  output logic [1:0]     rec_status,
  output logic           rec_dummy,
  output logic [3:0]     rec_rcode,
  output logic [TLW-1:0] rec_tlabel,
  output logic [NQ-1:0]  done,
  output logic [NQ-1:0]  err,
  output logic [NQ-1:0]  retry_act,
  input  logic           reg_wr,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata
);
  logic [NQ-1:0]  start_sel, kill, ack_sel, send_gnt, fin, fin_gnt;
  logic [QW-1:0]  fin_idx;
  logic           fin_any;
  logic [1:0]     t_stat  [NQ];
  logic           t_dummy [NQ];
  logic [3:0]     t_rcode [NQ];
  logic [IDW-1:0] t_dest  [NQ];
  logic [47:0]    t_off   [NQ];
  logic [3:0]     t_tcode [NQ];
  logic [1:0]     t_spd   [NQ];
  logic [TLW-1:0] t_tl    [NQ];
  logic [RW-1:0]  t_retry [NQ];
  logic [SW-1:0]  t_split [NQ];
  logic [2:0]     sel;
  logic [QW-1:0]  si;
  logic           sel_ok;
  logic [31:0]    rd_next;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign start_sel[i] = start_valid && (start_q == QW'(i));
    assign kill[i]      = bus_reset || (abort_valid && (abort_q == QW'(i)));
    assign ack_sel[i]   = tx_ack && send_gnt[i];
    xtm_timer #(.IDW(IDW), .TLW(TLW), .RW(RW), .SW(SW),
                .RETRY_LIMIT(RETRY_LIMIT), .SPLIT_TIMEOUT(SPLIT_TIMEOUT)) timer_i (
      .clk(clk), .rst(rst), .start(start_sel[i]),
      .start_dest(start_dest), .start_offset(start_offset), .start_tcode(start_tcode),
      .start_spd(start_spd), .start_tlabel(start_tlabel),
      .ack(ack_sel[i]), .ack_busy(tx_busy), .tick(tick),
      .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_tlabel(rsp_tlabel), .rsp_rcode(rsp_rcode),
      .kill(kill[i]), .grant(fin_gnt[i]),
      .sending(retry_act[i]), .finishing(fin[i]), .done(done[i]), .err(err[i]),
      .fin_status(t_stat[i]), .fin_dummy(t_dummy[i]), .fin_rcode(t_rcode[i]),
      .dest(t_dest[i]), .offset(t_off[i]), .tcode(t_tcode[i]), .spd(t_spd[i]),
      .tlabel(t_tl[i]), .retry(t_retry[i]), .split(t_split[i]));

    // R7: done rises only together with this queue's record or after a kill
    p_done_rise_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(done[i]) |-> ((rec_valid && rec_q == QW'(i)) || $past(kill[i])));
  end

  xtm_first #(.N(NQ)) send_pick_i (.req(retry_act), .gnt(send_gnt), .idx(tx_q), .any(tx_req));
  xtm_first #(.N(NQ)) fin_pick_i  (.req(fin & ~kill), .gnt(fin_gnt), .idx(fin_idx), .any(fin_any));

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;  rec_q <= '0;  rec_status <= '0;
      rec_dummy <= 1'b0;  rec_rcode <= '0;  rec_tlabel <= '0;
    end else begin
      rec_valid  <= fin_any;
      rec_q      <= fin_idx;
      rec_status <= t_stat[fin_idx];
      rec_dummy  <= t_dummy[fin_idx];
      rec_rcode  <= t_rcode[fin_idx];
      rec_tlabel <= t_tl[fin_idx];
    end
  end

  assign si     = sel[QW-1:0];
  assign sel_ok = (int'(sel) < NQ);

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        rd_next[2:0]     = sel;
        rd_next[8 +: NQ]  = done;
        rd_next[16 +: NQ] = err;
        rd_next[24 +: NQ] = retry_act;
      end
      ADDR_ST1: if (sel_ok) rd_next = {t_dest[si], t_off[si][47:32]};
      ADDR_ST2: if (sel_ok) rd_next = t_off[si][31:0];
      ADDR_ST3: if (sel_ok) rd_next = {t_tcode[si], t_spd[si], t_tl[si],
                                       4'(t_retry[si]), 16'(t_split[si])};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) sel <= reg_wdata[2:0];
      reg_rdata <= rd_next;
    end
  end

  // R7: a pushed record always finds its queue done with the matching error flag
  p_rec_marks_done_r7: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (done[rec_q] && (err[rec_q] == (rec_status != 2'd0))));
  // R7: never more than one finishing queue granted per cycle
  p_one_push_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(fin_gnt));
  // R10: the presented queue is in its send phase
  p_tx_owner_r10: assert property (@(posedge clk) disable iff (rst) tx_req |-> retry_act[tx_q]);
  // R9: a bus reset leaves no queue busy
  p_bus_reset_r9: assert property (@(posedge clk) disable iff (rst) bus_reset |=> (&done));
endmodule

// File: tb/xact_retry_mgr_tb_top.sv
module xact_retry_mgr_tb_top;
  localparam int NQ = 6;
  localparam int QW = 3;
  localparam int LIM = 3;
  localparam int TMO = 4;
  localparam int NV = 7;
  // vector: {queue[13:11], busy acks[10:9], mode[8:7] (0 response, 1 timeout, 2 exhaust),
  //          rcode[6:3], expected status[2:1], expected error[0]}
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 1'b0},
    {3'd1, 2'd2, 2'd0, 4'd4, 2'd1, 1'b1},
    {3'd2, 2'd3, 2'd2, 4'd0, 2'd2, 1'b1},
    {3'd3, 2'd1, 2'd1, 4'd0, 2'd3, 1'b1},
    {3'd4, 2'd0, 2'd0, 4'd0, 2'd0, 1'b0},
    {3'd5, 2'd0, 2'd1, 4'd0, 2'd3, 1'b1},
    {3'd1, 2'd0, 2'd0, 4'd0, 2'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_valid = 0, tx_ack = 0, tx_busy = 0, tick = 0, rsp_valid = 0;
  logic abort_valid = 0, bus_reset = 0, reg_wr = 0;
  logic [QW-1:0] start_q = 0, abort_q = 0, tx_q, rec_q;
  logic [15:0] start_dest = 0, rsp_src = 0;
  logic [47:0] start_offset = 0;
  logic [3:0] start_tcode = 0, rsp_rcode = 0, rec_rcode;
  logic [1:0] start_spd = 0, rec_status;
  logic [5:0] start_tlabel = 0, rsp_tlabel = 0, rec_tlabel;
  logic tx_req, rec_valid, rec_dummy;
  logic [NQ-1:0] done, err, retry_act;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int checks = 0, errors = 0;
  logic found;
  logic [QW-1:0] c_q;
  logic [1:0] c_st;
  logic c_dm;
  logic [NQ-1:0] c_done, c_err;
  logic [31:0] rdv;
  logic [13:0] e;
  logic [2:0] vq;
  logic [1:0] vnb, vmd, ves;
  logic [3:0] vrc;
  logic vee;
  logic [5:0] vtl;
  logic [15:0] vdest;

  always #10 clk = ~clk;

  xact_retry_mgr #(.NQ(NQ), .RETRY_LIMIT(LIM), .SPLIT_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_q(start_q),
    .start_dest(start_dest), .start_offset(start_offset), .start_tcode(start_tcode),
    .start_spd(start_spd), .start_tlabel(start_tlabel), .tx_req(tx_req), .tx_q(tx_q),
    .tx_ack(tx_ack), .tx_busy(tx_busy), .tick(tick), .rsp_valid(rsp_valid),
    .rsp_src(rsp_src), .rsp_tlabel(rsp_tlabel), .rsp_rcode(rsp_rcode),
    .abort_valid(abort_valid), .abort_q(abort_q), .bus_reset(bus_reset),
    .rec_valid(rec_valid), .rec_q(rec_q), .rec_status(rec_status), .rec_dummy(rec_dummy),
    .rec_rcode(rec_rcode), .rec_tlabel(rec_tlabel), .done(done), .err(err),
    .retry_act(retry_act), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic start(input logic [2:0] q, input logic [15:0] d, input logic [47:0] o,
                       input logic [5:0] tl);
    start_valid = 1; start_q = q; start_dest = d; start_offset = o;
    start_tcode = 4'h5; start_spd = 2'd2; start_tlabel = tl;
    @(negedge clk); start_valid = 0;
  endtask
  task automatic ack(input logic b);
    tx_ack = 1; tx_busy = b; @(negedge clk); tx_ack = 0;
  endtask
  task automatic rsp(input logic [15:0] s, input logic [5:0] tl, input logic [3:0] rc);
    rsp_valid = 1; rsp_src = s; rsp_tlabel = tl; rsp_rcode = rc;
    @(negedge clk); rsp_valid = 0;
  endtask
  task automatic ticks(input int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask
  task automatic abort(input logic [2:0] q);
    abort_valid = 1; abort_q = q; @(negedge clk); abort_valid = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a);
    reg_addr = a; @(negedge clk); rdv = reg_rdata;
  endtask
  task automatic wait_rec();
    found = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rec_valid) begin
        found = 1; c_q = rec_q; c_st = rec_status; c_dm = rec_dummy;
        c_done = done; c_err = err;
        break;
      end
    end
  endtask
  task automatic no_rec(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, rec_valid, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R1..) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done after reset", done, 6'h3F);
    chk("R1 err after reset", err, 6'h00);
    chk("R1 retry_act after reset", retry_act, 6'h00);
    chk("R1 tx_req after reset", tx_req, 1'b0);
    chk("R1 rec_valid after reset", rec_valid, 1'b0);

    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      vq = e[13:11]; vnb = e[10:9]; vmd = e[8:7]; vrc = e[6:3]; ves = e[2:1]; vee = e[0];
      vtl = 6'(v + 1); vdest = 16'hFFC0 + 16'(vq);
      start(vq, vdest, 48'h0000_1000_0000 + 48'(v), vtl);
      chk("R2 done cleared on start", done[vq], 1'b0);
      chk("R2 retry flag on start", retry_act[vq], 1'b1);
      chk("R10 tx_q names started queue", {tx_req, tx_q}, {1'b1, vq});
      for (int b = 0; b < int'(vnb); b++) ack(1'b1);
      if (vmd != 2'd2) begin
        chk("R3 still sending after busy", retry_act[vq], 1'b1);
        ack(1'b0);
        chk("R4 split wait flags", {done[vq], retry_act[vq]}, 2'b00);
        if (vmd == 2'd0) rsp(vdest, vtl, vrc);
        else ticks(TMO);
      end
      wait_rec();
      chk(vmd == 2'd2 ? "R3 busy exhaust record" : (vmd == 2'd1 ? "R4 timeout record" : "R5 response record"),
          {found, c_q, c_st, c_dm}, {1'b1, vq, ves, (vmd != 2'd0)});
      chk("R7 done and err at push", {c_done[vq], c_err[vq]}, {1'b1, vee});
      wr(8'h60, {29'd0, vq});
      rd(8'h6C);
      chk("R11 status3 window", rdv, {4'h5, 2'd2, vtl, 2'b00, vnb,
          (vmd == 2'd0) ? 16'(TMO) : 16'd0});
    end

    // R11 window detail for the control queue (timer 4) and zeroed select
    start(3'd4, 16'h1234, 48'hABCD_0123_4567, 6'd33);
    wr(8'h60, 32'd4);
    rd(8'h64); chk("R11 status1 dest and offset hi", rdv, 32'h1234_ABCD);
    rd(8'h68); chk("R11 status2 offset lo", rdv, 32'h0123_4567);
    rd(8'h60); chk("R11 ctrl sel, done4, retry4", {rdv[2:0], rdv[12], rdv[28]}, {3'd4, 1'b0, 1'b1});
    wr(8'h60, 32'd7);
    rd(8'h6C); chk("R11 out-of-range select reads zero", rdv, 32'd0);
    // R2 start on a busy queue is ignored
    start(3'd4, 16'h9999, 48'h0, 6'd1);
    wr(8'h60, 32'd4);
    rd(8'h64); chk("R2 second start ignored", rdv, 32'h1234_ABCD);
    // R8 abort: no record, done set
    abort(3'd4);
    chk("R8 done after abort", done[4], 1'b1);
    no_rec("R8 no record after abort", 4);
    // R8 abort keeps a set error flag
    start(3'd3, 16'h0203, 48'h0, 6'd2);
    abort(3'd3);
    chk("R8 err kept after abort", {done[3], err[3]}, 2'b11);

    // R6 unmatched responses ignored
    start(3'd0, 16'h0111, 48'h0, 6'd9);
    ack(1'b0);
    rsp(16'h0111, 6'd10, 4'd0);
    rsp(16'h0112, 6'd9, 4'd0);
    no_rec("R6 unmatched response no record", 3);
    chk("R6 still waiting", {done[0], retry_act[0]}, 2'b00);
    rsp(16'h0111, 6'd9, 4'd0);
    wait_rec();
    chk("R6 matched response after misses", {found, c_q, c_st, c_dm}, {1'b1, 3'd0, 2'd0, 1'b0});

    // R10 priority and R7 ordering of simultaneous finishes
    start(3'd3, 16'h0303, 48'h0, 6'd3);
    start(3'd1, 16'h0301, 48'h0, 6'd4);
    chk("R10 lowest queue presented", tx_q, 3'd1);
    ack(1'b0);
    chk("R10 ack went to queue 1", {retry_act[1], retry_act[3], tx_q}, {1'b0, 1'b1, 3'd3});
    ack(1'b0);
    ticks(TMO);
    wait_rec();
    chk("R7 first push lower queue", {found, c_q, c_st, c_done[3]}, {1'b1, 3'd1, 2'd3, 1'b0});
    @(negedge clk);
    chk("R7 second push next cycle", {rec_valid, rec_q, rec_status, done[3]}, {1'b1, 3'd3, 2'd3, 1'b1});

    // R9 bus reset drops everything
    start(3'd0, 16'h0400, 48'h0, 6'd5);
    start(3'd5, 16'h0405, 48'h0, 6'd6);
    ack(1'b0);
    bus_reset = 1; @(negedge clk); bus_reset = 0;
    chk("R9 all done after bus reset", {done, tx_req}, {6'h3F, 1'b0});
    no_rec("R9 no record after bus reset", 4);

    summary();
    $finish;
  end
endmodule